// File: doc/BRIEF.md
# Multi-Mode Programmable Delay Timer

This block is a synchronous delay timer steered by a single trigger input. It drives two complementary outputs. In steady state the primary output `out1` is the inverse of the trigger level, and the secondary output `out2` is its complement. A 2-bit mode field chooses which trigger edges, if any, are delayed before the outputs follow the trigger: rising edges only, falling edges only, both, or a fixed-length pulse from any edge. A 3-bit scale code picks the delay length. The delay is a power of a parameter base (default 10), counted in cycles where the timer tick enable is high.

Every trigger edge captures the mode, scale and flash settings, and the timer uses those captured copies until the next edge. When the captured flash setting is high, `out2` becomes a busy indicator instead: a train of short pulses, clocked by a separate flash tick enable, that runs only while a delay is pending. The synchronous reset aborts any timing. When reset is released, the block reconciles its outputs with the trigger level under the mode present at that moment.

Top module: `delay_timer`

## Requirements
- R1: The mode field `mode_sel` encodes 2'b00 as on-delay, 2'b01 as off-delay, 2'b10 as dual-delay and 2'b11 as one-shot.
- R2: While `rst` is high, `out1` is 1, `out2` is 0 and any pending delay is abandoned. From the clock edge after `rst` is first seen high, both outputs show these values.
- R3: In on-delay, a rising trigger edge makes `out1` fall only once the delay has elapsed. A falling edge raises `out1` on the first clock edge that sees the new trigger level.
- R4: In off-delay, a falling trigger edge raises `out1` only after the delay. A rising edge lowers `out1` at once.
- R5: In dual-delay, both edge directions are delayed before `out1` follows the inverted trigger.
- R6: In one-shot, any trigger edge drives `out1` to 0 (and `out2` to 1) at once. After the delay they return to 1 and 0, whatever the trigger level.
- R7: The mode, scale code and flash enable are captured only at a trigger edge or at reset release. Changing them at any other time does not affect the timing in progress.
- R8: An edge that arrives during a delay restarts the count with the newly captured settings. If the trigger returns to the level that already matches `out1`, the pending change is cancelled. Outside these events and delay completion, `out1` does not change.
- R9: On the first clock with `rst` low, the trigger level is compared with `out1` and the mismatch is resolved as if it were an edge to that level. In one-shot mode, no change happens.
- R10: Scale code k gives a delay of BASE^k ticks. A tick is a cycle with `tick_en` high, excluding the event cycle. `out1` switches on the clock edge of the last tick.
- R11: With flash captured high, `out2` is high for 2 flash ticks at the start of each period while a delay runs, and is low otherwise. The period is 20 flash ticks for scale codes 3 and 4, and 100 for the others.
- R12: With flash captured low, `out2` is always the complement of `out1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous clear, active high; its release triggers reconciliation |
| trig | input | 1 | Trigger level; both edges are events |
| mode_sel | input | 2 | Mode field, captured at events |
| scale_sel | input | 3 | Scale code, captured at events |
| flash_en | input | 1 | Busy-indicator select for out2, captured at events |
| tick_en | input | 1 | Timer tick enable |
| flash_tick | input | 1 | Flash tick enable |
| out1 | output | 1 | Primary output, inverse of the trigger in steady state |
| out2 | output | 1 | Complement of out1, or the busy pulse train |

## Verification
The hardest situation to reach is an event that lands while a delay is already running with different captured settings. One example is a mode change that stays invisible until the next edge. Another is a trigger return that must cancel rather than restart. Directed sequences reach these cases by rewriting the configuration pins in the middle of a delay, and by toggling the trigger back a few ticks into a long count. Reset is also released with the trigger high under each mode. A long randomized stretch with sparse tick enables then mixes edges, mode changes and resets against the cycle-level reference model.

// File: rtl/dly_pkg.sv
package dly_pkg;

   typedef enum logic [1:0] {
      MD_ON      = 2'b00,
      MD_OFF     = 2'b01,
      MD_DUAL    = 2'b10,
      MD_ONESHOT = 2'b11
   } dly_mode_e;

   localparam int SCALE_CODES = 8;
   localparam int SCALE_W     = 3;

   // Codes that select the short flash period.
   function automatic logic short_period(input logic [SCALE_W-1:0] code);
      return (code == 3'd3) || (code == 3'd4);
   endfunction

   // Whether an edge to level lvl is delayed in mode m (non one-shot modes).
   function automatic logic edge_is_delayed(input dly_mode_e m, input logic lvl);
      case (m)
         MD_ON:   return lvl;
         MD_OFF:  return !lvl;
         MD_DUAL: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/dly_edge.sv
module dly_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic trig,
   output logic trig_lvl,
   output logic edge_ev,
   output logic rel,
   output logic ev
);
   logic trig_s;
   logic trig_q;
   logic rst_p;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign trig_s = trig;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk) begin
            sh[0] <= trig;
            for (int i = 1; i < SYNC_STAGES; i++) sh[i] <= sh[i-1];
         end
         assign trig_s = sh[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      trig_q <= trig_s;
      rst_p  <= rst;
   end

   assign trig_lvl = trig_s;
   assign edge_ev  = !rst && (trig_s != trig_q);
   assign rel      = !rst && rst_p;
   assign ev       = edge_ev || rel;

endmodule

// File: rtl/dly_cfg.sv
module dly_cfg
   import dly_pkg::*;
#(
   parameter int BASE  = 10,
   parameter int CNT_W = 24
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ev,
   input  logic [1:0]         mode_sel,
   input  logic [SCALE_W-1:0] scale_sel,
   input  logic               flash_en,
   output dly_mode_e          mode_l,
   output logic [CNT_W-1:0]   lim_l,
   output logic               short_l,
   output logic               flash_l
);
   logic [CNT_W-1:0] tab [SCALE_CODES];

   generate
      for (genvar k = 0; k < SCALE_CODES; k++) begin : g_tab
         localparam int unsigned LV = BASE ** k;
         assign tab[k] = CNT_W'(LV);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_l  <= MD_ON;
         lim_l   <= tab[0];
         short_l <= 1'b0;
         flash_l <= 1'b0;
      end else if (ev) begin
         mode_l  <= dly_mode_e'(mode_sel);
         lim_l   <= tab[scale_sel];
         short_l <= short_period(scale_sel);
         flash_l <= flash_en;
      end
   end

endmodule

// File: rtl/dly_core.sv
module dly_core
   import dly_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ev,
   input  logic             edge_ev,
   input  logic             trig_lvl,
   input  logic [1:0]       mode_sel,
   input  logic [CNT_W-1:0] lim_l,
   input  logic             tick_en,
   output logic             out1,
   output logic             run
);
   logic [CNT_W-1:0] cnt;
   logic             tgt;
   dly_mode_e        mode_now;

   assign mode_now = dly_mode_e'(mode_sel);

   always_ff @(posedge clk) begin
      if (rst) begin
         out1 <= 1'b1;
         run  <= 1'b0;
         cnt  <= '0;
         tgt  <= 1'b1;
      end else if (ev) begin
         cnt <= '0;
         if (mode_now == MD_ONESHOT) begin
            if (edge_ev) begin
               out1 <= 1'b0;
               run  <= 1'b1;
               tgt  <= 1'b1;
            end else begin
               run <= 1'b0;
            end
         end else if (out1 == !trig_lvl) begin
            run <= 1'b0;
         end else if (edge_is_delayed(mode_now, trig_lvl)) begin
            run <= 1'b1;
            tgt <= !trig_lvl;
         end else begin
            out1 <= !trig_lvl;
            run  <= 1'b0;
         end
      end else if (run && tick_en) begin
         if (cnt == lim_l - 1'b1) begin
            run  <= 1'b0;
            out1 <= tgt;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/dly_flash.sv
module dly_flash #(
   parameter int PULSE_W    = 2,
   parameter int PER_SHORT  = 20,
   parameter int PER_LONG   = 100
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   input  logic run,
   input  logic ftick,
   input  logic short_l,
   output logic pulse
);
   localparam int FC_W = $clog2(PER_LONG + 1);

   logic [FC_W-1:0] fcnt;
   logic [FC_W-1:0] last;

   assign last = short_l ? FC_W'(PER_SHORT - 1) : FC_W'(PER_LONG - 1);

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         fcnt <= '0;
      end else if (run && ftick) begin
         fcnt <= (fcnt == last) ? '0 : fcnt + 1'b1;
      end
   end

   assign pulse = run && (fcnt < FC_W'(PULSE_W));

endmodule

// File: rtl/delay_timer.sv
module delay_timer
   import dly_pkg::*;
#(
   parameter int BASE        = 10,
   parameter int SYNC_STAGES = 0,
   parameter int PULSE_W     = 2,
   parameter int PER_SHORT   = 20,
   parameter int PER_LONG    = 100
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       trig,
   input  logic [1:0] mode_sel,
   input  logic [2:0] scale_sel,
   input  logic       flash_en,
   input  logic       tick_en,
   input  logic       flash_tick,
   output logic       out1,
   output logic       out2
);
   localparam int unsigned MAX_LIM = BASE ** (SCALE_CODES - 1);
   localparam int          CNT_W   = $clog2(MAX_LIM + 1) + 1;

   generate
      if (BASE < 2 || BASE > 20) begin : g_bad_base
         $error("delay_timer: BASE must lie in 2..20");
      end
      if (PULSE_W < 1 || PULSE_W >= PER_SHORT || PER_SHORT > PER_LONG) begin : g_bad_flash
         $error("delay_timer: need 1 <= PULSE_W < PER_SHORT <= PER_LONG");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("delay_timer: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic             trig_lvl, edge_ev, rel, ev;
   dly_mode_e        mode_l;
   logic [CNT_W-1:0] lim_l;
   logic             short_l, flash_l;
   logic             run, pulse;

   dly_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst(rst), .trig(trig),
      .trig_lvl(trig_lvl), .edge_ev(edge_ev), .rel(rel), .ev(ev)
   );

   dly_cfg #(.BASE(BASE), .CNT_W(CNT_W)) u_cfg (
      .clk(clk), .rst(rst), .ev(ev),
      .mode_sel(mode_sel), .scale_sel(scale_sel), .flash_en(flash_en),
      .mode_l(mode_l), .lim_l(lim_l), .short_l(short_l), .flash_l(flash_l)
   );

   dly_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst(rst), .ev(ev), .edge_ev(edge_ev), .trig_lvl(trig_lvl),
      .mode_sel(mode_sel), .lim_l(lim_l), .tick_en(tick_en),
      .out1(out1), .run(run)
   );

   dly_flash #(.PULSE_W(PULSE_W), .PER_SHORT(PER_SHORT), .PER_LONG(PER_LONG)) u_flash (
      .clk(clk), .rst(rst), .restart(ev), .run(run),
      .ftick(flash_tick), .short_l(short_l), .pulse(pulse)
   );

   assign out2 = flash_l ? pulse : !out1;

endmodule

// File: rtl/dly_timer_chk.sv
module dly_timer_chk
   import dly_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input logic             clk,
   input logic             rst,
   input logic [1:0]       mode_sel,
   input logic             tick_en,
   input logic             ev,
   input logic             edge_ev,
   input logic             rel,
   input logic             run,
   input dly_mode_e        mode_l,
   input logic [CNT_W-1:0] lim_l,
   input logic             flash_l,
   input logic             out1,
   input logic             out2
);
   logic rst_q = 1'b0;
   always_ff @(posedge clk) rst_q <= rst;

   always @(posedge clk) begin
      if (rst_q && rst)
         AST_RESET_OUTPUTS: assert (out1 === 1'b1 && out2 === 1'b0); // R2
   end

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
      !ev |=> ($stable(mode_l) && $stable(lim_l) && $stable(flash_l))); // R7

   AST_NO_TICK_NO_SWITCH: assert property (@(posedge clk) disable iff (rst)
      (run && !ev && !tick_en) |=> $stable(out1)); // R10

   AST_ONESHOT_FIRE: assert property (@(posedge clk) disable iff (rst)
      (edge_ev && mode_sel == 2'b11) |=> (!out1 && run)); // R6

   AST_ONESHOT_RELEASE_QUIET: assert property (@(posedge clk) disable iff (rst)
      (rel && !edge_ev && mode_sel == 2'b11) |=> (out1 && !out2)); // R9

   AST_IDLE_OUT1_STABLE: assert property (@(posedge clk) disable iff (rst)
      (!ev && !run) |=> $stable(out1)); // R8

   AST_FLASH_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
      (flash_l && !run) |-> !out2); // R11

endmodule

bind delay_timer dly_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .mode_sel(mode_sel), .tick_en(tick_en),
   .ev(ev), .edge_ev(edge_ev), .rel(rel), .run(run),
   .mode_l(mode_l), .lim_l(lim_l), .flash_l(flash_l),
   .out1(out1), .out2(out2)
);

// File: tb/sim_delay_timer.sv
`timescale 1ns/1ps
module sim_delay_timer;
   localparam int BASE = 3;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       trig = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic [2:0] scale_sel = 3'd0;
   logic       flash_en = 1'b0;
   logic       tick_en = 1'b1;
   logic       flash_tick = 1'b1;
   logic       out1, out2;

   always #5 clk = ~clk;

   delay_timer #(.BASE(BASE)) u0 (
      .clk(clk), .rst(rst), .trig(trig), .mode_sel(mode_sel),
      .scale_sel(scale_sel), .flash_en(flash_en), .tick_en(tick_en),
      .flash_tick(flash_tick), .out1(out1), .out2(out2)
   );

   int    n_vec = 0, n_bad = 0, cyc_n = 0;
   int    tdiv = 1, fdiv = 1;
   string cur_req = "R2";
   bit    done = 0;

   // reference model state
   int m_out1 = 1, m_run = 0, m_cnt = 0, m_tgt = 1, m_lim = 1;
   int m_short = 0, m_fl = 0, m_fcnt = 0, m_trq = 0, m_rstp = 1;

   function automatic int pw(int c);
      int v = 1;
      for (int i = 0; i < c; i++) v = v * BASE;
      return v;
   endfunction

   task automatic model_step();
      int old_run = m_run;
      if (rst) begin
         m_out1 = 1; m_run = 0; m_cnt = 0; m_tgt = 1; m_lim = 1;
         m_short = 0; m_fl = 0; m_fcnt = 0; m_rstp = 1; m_trq = trig;
      end else begin
         bit e_edge = (trig != m_trq);
         bit e_rel  = m_rstp;
         m_rstp = 0; m_trq = trig;
         if (e_edge || e_rel) begin
            m_lim = pw(scale_sel); m_short = (scale_sel == 3 || scale_sel == 4);
            m_fl = flash_en; m_fcnt = 0; m_cnt = 0;
            if (mode_sel == 2'b11) begin
               if (e_edge) begin m_out1 = 0; m_run = 1; m_tgt = 1; end
               else m_run = 0;
            end else begin
               int want = trig ? 0 : 1;
               bit dly = (mode_sel == 2'b10) || (mode_sel == 2'b00 && trig) ||
                         (mode_sel == 2'b01 && !trig);
               if (m_out1 == want) m_run = 0;
               else if (dly) begin m_run = 1; m_tgt = want; end
               else begin m_out1 = want; m_run = 0; end
            end
         end else begin
            if (old_run && flash_tick)
               m_fcnt = (m_fcnt == (m_short ? 19 : 99)) ? 0 : m_fcnt + 1;
            if (m_run && tick_en) begin
               if (m_cnt == m_lim - 1) begin m_run = 0; m_out1 = m_tgt; end
               else m_cnt++;
            end
         end
      end
   endtask

   task automatic cyc();
      int e2;
      @(posedge clk);
      model_step();
      #2;
      e2 = m_fl ? (m_run && m_fcnt < 2) : !m_out1;
      n_vec++;
      if (out1 !== m_out1[0] || out2 !== e2[0]) begin
         n_bad++;
         $display("FAIL %s cycle %0d: out1/out2 = %b/%b, expected %0d/%0d",
                  cur_req, cyc_n, out1, out2, m_out1, e2);
      end
      cyc_n++;
      tick_en    = (tdiv <= 1) || (cyc_n % tdiv == 0);
      flash_tick = (fdiv <= 1) || (cyc_n % fdiv == 0);
   endtask

   task automatic run_n(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic do_reset(bit t, bit [1:0] m, bit [2:0] s, bit f);
      rst = 1; run_n(3);
      trig = t; mode_sel = m; scale_sel = s; flash_en = f;
      run_n(2);
      rst = 0;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #1_500_000;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_up();
   end

   initial begin
      cur_req = "R2"; run_n(4);
      // R3 on-delay, scale code 2 = 9 ticks
      cur_req = "R3"; do_reset(0, 2'b00, 3'd2, 0); run_n(4);
      trig = 1; run_n(15); trig = 0; run_n(5);
      // R10 sparse ticks
      cur_req = "R10"; tdiv = 3; scale_sel = 3'd1; trig = 1; run_n(20);
      scale_sel = 3'd0; trig = 0; run_n(6); trig = 1; run_n(8); tdiv = 1;
      trig = 0; run_n(4);
      // R4 off-delay
      cur_req = "R4"; mode_sel = 2'b01; scale_sel = 3'd2; trig = 1; run_n(4);
      trig = 0; run_n(15);
      // R5 dual-delay
      cur_req = "R5"; mode_sel = 2'b10; trig = 1; run_n(14); trig = 0; run_n(14);
      // R6 one-shot from both edges
      cur_req = "R6"; mode_sel = 2'b11; scale_sel = 3'd1; trig = 1; run_n(8);
      trig = 0; run_n(8);
      // R7 config change mid-run ignored
      cur_req = "R7"; mode_sel = 2'b00; scale_sel = 3'd3; trig = 1; run_n(5);
      mode_sel = 2'b01; scale_sel = 3'd0; flash_en = 1; run_n(30);
      flash_en = 0; trig = 0; run_n(4);
      // R8 restart and cancel
      cur_req = "R8"; mode_sel = 2'b10; scale_sel = 3'd2; trig = 1; run_n(4);
      trig = 0; run_n(5); trig = 1; run_n(4); scale_sel = 3'd1; trig = 0; run_n(2);
      trig = 1; run_n(14);
      mode_sel = 2'b11; trig = 0; run_n(2); trig = 1; run_n(2); trig = 0; run_n(10);
      // R9 reconciliation at release
      cur_req = "R9"; do_reset(1, 2'b01, 3'd2, 0); run_n(6);
      do_reset(1, 2'b00, 3'd2, 0); run_n(14);
      do_reset(1, 2'b11, 3'd2, 0); run_n(6);
      do_reset(1, 2'b10, 3'd1, 1); run_n(8);
      // R11 flash: short period (code 3) and long period (code 5)
      cur_req = "R11"; do_reset(0, 2'b00, 3'd3, 1); run_n(3);
      trig = 1; run_n(40); fdiv = 2; scale_sel = 3'd5; trig = 0; run_n(3);
      trig = 1; run_n(260); fdiv = 1;
      scale_sel = 3'd4; mode_sel = 2'b11; trig = 0; run_n(100);
      // R12 out2 tracks out1 with flash off; R1 all mode codes in mix
      cur_req = "R12"; flash_en = 0; mode_sel = 2'b01; trig = 1; run_n(6);
      trig = 0; run_n(100);
      // R1 randomized mixing of modes, codes, edges and resets
      cur_req = "R1";
      for (int k = 0; k < 6000; k++) begin
         int r = $urandom_range(0, 99);
         if (r < 6) trig = ~trig;
         else if (r < 9) mode_sel = 2'($urandom_range(0, 3));
         else if (r < 11) scale_sel = 3'($urandom_range(0, 3));
         else if (r < 13) flash_en = ~flash_en;
         else if (r == 13) tdiv = $urandom_range(1, 3);
         else if (r == 14) fdiv = $urandom_range(1, 2);
         rst = (k % 997 < 2);
         cyc();
      end
      rst = 0; run_n(5);
      finish_up();
   end
endmodule